// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is the datapath of one DMA channel. A register block loads a 16-bit start address and a 16-bit unit count (the count holds one less than the number of units), supplies an 8-bit page value and an auto-initialise flag, and opens or closes the channel through mask controls. The engine keeps a base and a current copy of both the address and the count. While the channel is open and the attached device holds its request line, the engine moves one unit per clock. For each unit it presents a physical memory address and a one-cycle strobe, and it steps the address up and the count down.

When the last unit of a block has moved, a one-cycle terminal-count pulse is raised. With auto-initialise on, the current address and count are refilled from their base copies and the channel stays open. With auto-initialise off, the address keeps its advanced value, the count rolls to 0xFFFF and the channel closes itself. The parameter `WIDE` picks byte units (0) or 16-bit word units (1). In word mode the lowest page bit is not used and the address is doubled. Every change of the mask raises a one-cycle mask or unmask event for the device.

The control is a three-state machine. `ST_WAIT` means no unit moved at the last edge. `ST_MOVE` means a unit moved that was not the last one. `ST_LAST` means the final unit of a block moved. From every state the same transitions apply on each edge: an open channel with a request goes to `ST_LAST` when the current count is zero and to `ST_MOVE` otherwise, and any other condition goes to `ST_WAIT`. The strobe is high in `ST_MOVE` and `ST_LAST`. The terminal-count pulse is high only in `ST_LAST`.

Top module: `dma_unit_engine`

## Requirements
- R1: After reset the channel is masked, no strobe, terminal-count pulse or event is raised, and the current address, current count and physical address are all zero.
- R2: A unit is moved at a clock edge only if the mask is clear and `dreq` is high at that edge. At most one unit moves per edge, and `xfer_stb` is high for the one cycle that follows that edge.
- R3: Each moved unit raises the current address by one and lowers the current count by one, unless the unit ends the block.
- R4: With `WIDE`=0 the physical address of a unit is {page, current address} (24 bits), taken from the address before it steps.
- R5: With `WIDE`=1 the physical address is {page[7:1], current address, 1'b0}, so the page base is (page>>1)<<17 and the word offset is doubled.
- R6: A loaded count N moves N+1 units. `tc_pulse` is high together with the strobe of the last unit, and only then.
- R7: At terminal count with `auto_init` high, the current address and current count are refilled from their base copies and the channel stays unmasked.
- R8: At terminal count with `auto_init` low, the current address keeps its advanced value, the current count becomes 0xFFFF and the mask is set.
- R9: `mask_evt` is high for one cycle when the mask goes from 0 to 1, and `unmask_evt` is high for one cycle when it goes from 1 to 0. A mask command that leaves the mask unchanged raises neither.
- R10: A host load of address or count in the same cycle as a unit move wins over the engine's own update. A load writes both the base copy and the current copy.
- R11: The current address wraps from 0xFFFF to 0x0000 and never changes the page bits of the physical address.
- R12: When `mask_set` and `mask_clr` are both high, the mask is set. A terminal-count self-mask wins over a `mask_clr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_addr_en | input | 1 | Load base and current address |
| wr_addr_val | input | 16 | Address value to load |
| wr_cnt_en | input | 1 | Load base and current count |
| wr_cnt_val | input | 16 | Count value to load (units minus one) |
| page_sel | input | 8 | Page register value |
| auto_init | input | 1 | Refill at terminal count when high |
| mask_set | input | 1 | Set the channel mask |
| mask_clr | input | 1 | Clear the channel mask |
| dreq | input | 1 | Device request |
| xfer_stb | output | 1 | One-cycle strobe per moved unit |
| phys_addr | output | 24 | Byte address of the last moved unit |
| tc_pulse | output | 1 | Terminal-count pulse |
| mask_o | output | 1 | Current mask state |
| mask_evt | output | 1 | Mask went from 0 to 1 |
| unmask_evt | output | 1 | Mask went from 1 to 0 |
| cur_addr_o | output | 16 | Current address |
| cur_cnt_o | output | 16 | Current count |

## Verification
Two pairs of actions can land in the same cycle. The first pair is a host load of the address or count and the engine stepping that same register. The second pair is a terminal-count self-mask and a host mask command. The bench sets up both pairs on purpose: it drives `wr_addr_en` on an edge where `dreq` moves a unit, and it raises `mask_clr` or `mask_set` together with `mask_clr` around a block end. A behavioural model then decides the result, giving the host load and the set command priority. A long pseudo-random phase also creates these collisions by chance, and it is compared with the model on every clock for both the byte and the word variant.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_MOVE = 2'd1,
        ST_LAST = 2'd2
    } xfer_state_e;
endpackage

// File: rtl/dma_phys_map.sv
module dma_phys_map #(
    parameter int WIDE   = 0,
    parameter int PAGE_W = 8,
    parameter int ADDR_W = 16,
    localparam int PHYS_W = PAGE_W + ADDR_W
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [ADDR_W-1:0] addr,
    output logic [PHYS_W-1:0] phys
);
    generate
        if (WIDE != 0) begin : g_word
            // lowest page bit unused; word offset doubled
            assign phys = {page[PAGE_W-1:1], addr, 1'b0};
        end else begin : g_byte
            assign phys = {page, addr};
        end
    endgenerate
endmodule

// File: rtl/dma_cursor.sv
module dma_cursor #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_addr,
    input  logic [ADDR_W-1:0] ld_addr_val,
    input  logic              ld_cnt,
    input  logic [ADDR_W-1:0] ld_cnt_val,
    input  logic              step,
    input  logic              refill,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] cur_cnt,
    output logic              last
);
    logic [ADDR_W-1:0] base_addr, base_cnt;

    assign last = (cur_cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_addr <= '0;
            cur_addr  <= '0;
        end else if (ld_addr) begin
            base_addr <= ld_addr_val;
            cur_addr  <= ld_addr_val;
        end else if (step) begin
            cur_addr <= (last && refill) ? base_addr : cur_addr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_cnt <= '0;
            cur_cnt  <= '0;
        end else if (ld_cnt) begin
            base_cnt <= ld_cnt_val;
            cur_cnt  <= ld_cnt_val;
        end else if (step) begin
            if (last) cur_cnt <= refill ? base_cnt : '1;
            else      cur_cnt <= cur_cnt - 1'b1;
        end
    end

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !last && !ld_addr) |=> cur_addr == $past(cur_addr) + 1'b1); // R3
    AST_STEP_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !last && !ld_cnt) |=> cur_cnt == $past(cur_cnt) - 1'b1); // R3
    AST_END_ROLLS_OVER: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last && !refill && !ld_cnt) |=> cur_cnt == '1); // R8
    AST_HOST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_addr |=> cur_addr == $past(ld_addr_val)); // R10
endmodule

// File: rtl/dma_mask_ctl.sv
module dma_mask_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic host_set,
    input  logic host_clr,
    input  logic self_set,
    output logic mask,
    output logic mask_evt,
    output logic unmask_evt
);
    logic mask_n;

    always_comb begin
        if (host_set || self_set) mask_n = 1'b1;
        else if (host_clr)        mask_n = 1'b0;
        else                      mask_n = mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask       <= 1'b1;
            mask_evt   <= 1'b0;
            unmask_evt <= 1'b0;
        end else begin
            mask       <= mask_n;
            mask_evt   <= mask_n & ~mask;
            unmask_evt <= ~mask_n & mask;
        end
    end

    AST_MASK_EVT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        mask_evt |-> (mask && !$past(mask))); // R9
    AST_UNMASK_EVT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        unmask_evt |-> (!mask && $past(mask))); // R9
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_set || self_set) |=> mask); // R12
endmodule

// File: rtl/dma_unit_engine.sv
module dma_unit_engine #(
    parameter int WIDE   = 0,
    parameter int PAGE_W = 8,
    parameter int ADDR_W = 16,
    localparam int PHYS_W = PAGE_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr_en,
    input  logic [ADDR_W-1:0] wr_addr_val,
    input  logic              wr_cnt_en,
    input  logic [ADDR_W-1:0] wr_cnt_val,
    input  logic [PAGE_W-1:0] page_sel,
    input  logic              auto_init,
    input  logic              mask_set,
    input  logic              mask_clr,
    input  logic              dreq,
    output logic              xfer_stb,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              tc_pulse,
    output logic              mask_o,
    output logic              mask_evt,
    output logic              unmask_evt,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [ADDR_W-1:0] cur_cnt_o
);
    import dma_eng_pkg::*;

    xfer_state_e       state, state_n;
    logic              svc, last, self_set;
    logic [PHYS_W-1:0] phys_now;

    assign svc      = !mask_o && dreq;
    assign self_set = svc && last && !auto_init;

    dma_cursor #(.ADDR_W(ADDR_W)) u_cursor (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_addr     (wr_addr_en),
        .ld_addr_val (wr_addr_val),
        .ld_cnt      (wr_cnt_en),
        .ld_cnt_val  (wr_cnt_val),
        .step        (svc),
        .refill      (auto_init),
        .cur_addr    (cur_addr_o),
        .cur_cnt     (cur_cnt_o),
        .last        (last)
    );

    dma_mask_ctl u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_set   (mask_set),
        .host_clr   (mask_clr),
        .self_set   (self_set),
        .mask       (mask_o),
        .mask_evt   (mask_evt),
        .unmask_evt (unmask_evt)
    );

    dma_phys_map #(.WIDE(WIDE), .PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_map (
        .page (page_sel),
        .addr (cur_addr_o),
        .phys (phys_now)
    );

    // next-state logic
    always_comb begin
        state_n = ST_WAIT;
        unique case (state)
            ST_WAIT, ST_MOVE, ST_LAST: begin
                if (svc) state_n = last ? ST_LAST : ST_MOVE;
                else     state_n = ST_WAIT;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= state_n;
    end

    // outputs decoded from state
    always_comb begin
        xfer_stb = 1'b0;
        tc_pulse = 1'b0;
        unique case (state)
            ST_WAIT: ;
            ST_MOVE: xfer_stb = 1'b1;
            ST_LAST: begin
                xfer_stb = 1'b1;
                tc_pulse = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   phys_addr <= '0;
        else if (svc) phys_addr <= phys_now;
    end

    AST_STB_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_stb |-> $past(!mask_o && dreq)); // R2
    AST_TC_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> ($past(cur_cnt_o) == '0 || $past(wr_cnt_en))); // R6
    AST_END_SELF_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pulse && !$past(auto_init)) |-> mask_o); // R8
    AST_AUTO_STAYS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pulse && $past(auto_init) && !$past(mask_set)) |-> !mask_o); // R7
endmodule

// File: tb/dma_unit_engine_test.sv
`timescale 1ns/1ps
module dma_unit_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_addr_en = 0, wr_cnt_en = 0;
    logic [15:0] wr_addr_val = 0, wr_cnt_val = 0;
    logic [7:0]  page_sel = 0;
    logic        auto_init = 0, mask_set = 0, mask_clr = 0, dreq = 0;

    logic        xfer_stb, tc_pulse, mask_o, mask_evt, unmask_evt;
    logic [23:0] phys_addr;
    logic [15:0] cur_addr_o, cur_cnt_o;
    logic        xfer_stb_w, tc_w, mask_w, mevt_w, uevt_w;
    logic [23:0] phys_w;
    logic [15:0] addr_w, cnt_w;

    always #2.5 clk = ~clk;

    dma_unit_engine #(.WIDE(0)) uut (
        .clk(clk), .rst_n(rst_n), .wr_addr_en(wr_addr_en), .wr_addr_val(wr_addr_val),
        .wr_cnt_en(wr_cnt_en), .wr_cnt_val(wr_cnt_val), .page_sel(page_sel),
        .auto_init(auto_init), .mask_set(mask_set), .mask_clr(mask_clr), .dreq(dreq),
        .xfer_stb(xfer_stb), .phys_addr(phys_addr), .tc_pulse(tc_pulse), .mask_o(mask_o),
        .mask_evt(mask_evt), .unmask_evt(unmask_evt), .cur_addr_o(cur_addr_o),
        .cur_cnt_o(cur_cnt_o));

    dma_unit_engine #(.WIDE(1)) uut_w (
        .clk(clk), .rst_n(rst_n), .wr_addr_en(wr_addr_en), .wr_addr_val(wr_addr_val),
        .wr_cnt_en(wr_cnt_en), .wr_cnt_val(wr_cnt_val), .page_sel(page_sel),
        .auto_init(auto_init), .mask_set(mask_set), .mask_clr(mask_clr), .dreq(dreq),
        .xfer_stb(xfer_stb_w), .phys_addr(phys_w), .tc_pulse(tc_w), .mask_o(mask_w),
        .mask_evt(mevt_w), .unmask_evt(uevt_w), .cur_addr_o(addr_w), .cur_cnt_o(cnt_w));

    int n_cmp = 0, n_bad = 0;
    int n_stb = 0, n_tc = 0;
    bit done = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference
    bit          m_mask, m_stb, m_tc, m_mevt, m_uevt;
    logic [15:0] m_addr, m_cnt, m_baddr, m_bcnt;
    logic [23:0] m_phys, m_physw;
    bit          m_svc, m_end, m_self, m_next;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask = 1; m_stb = 0; m_tc = 0; m_mevt = 0; m_uevt = 0;
            m_addr = 0; m_cnt = 0; m_baddr = 0; m_bcnt = 0; m_phys = 0; m_physw = 0;
        end else begin
            m_svc = !m_mask && dreq;
            m_end = (m_cnt == 16'h0000);
            m_stb = m_svc;
            m_tc  = m_svc && m_end;
            if (m_svc) begin
                m_phys  = 24'(int'(page_sel) * 65536 + int'(m_addr));
                m_physw = 24'((int'(page_sel) / 2) * 131072 + int'(m_addr) * 2);
            end
            m_self = m_tc && !auto_init;
            if (mask_set || m_self) m_next = 1;
            else if (mask_clr)      m_next = 0;
            else                    m_next = m_mask;
            m_mevt = m_next && !m_mask;
            m_uevt = !m_next && m_mask;
            m_mask = m_next;
            if (wr_addr_en) begin
                m_addr = wr_addr_val; m_baddr = wr_addr_val;
            end else if (m_svc) begin
                if (m_tc && auto_init) m_addr = m_baddr;
                else                   m_addr = 16'((int'(m_addr) + 1) % 65536);
            end
            if (wr_cnt_en) begin
                m_cnt = wr_cnt_val; m_bcnt = wr_cnt_val;
            end else if (m_svc) begin
                if (m_tc) m_cnt = auto_init ? m_bcnt : 16'hFFFF;
                else      m_cnt = m_cnt - 16'd1;
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 strobe", {31'd0, xfer_stb}, {31'd0, m_stb});
            check("R6 tc", {31'd0, tc_pulse}, {31'd0, m_tc});
            check("R4 phys byte", {8'd0, phys_addr}, {8'd0, m_phys});
            check("R5 phys word", {8'd0, phys_w}, {8'd0, m_physw});
            check("R3 addr", {16'd0, cur_addr_o}, {16'd0, m_addr});
            check("R3 count", {16'd0, cur_cnt_o}, {16'd0, m_cnt});
            check("R8 mask", {31'd0, mask_o}, {31'd0, m_mask});
            check("R9 mask event", {30'd0, mask_evt, unmask_evt}, {30'd0, m_mevt, m_uevt});
            check("R5 word strobe", {31'd0, xfer_stb_w}, {31'd0, m_stb});
            if (xfer_stb) n_stb++;
            if (tc_pulse) n_tc++;
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #100000;
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: actual hung expected finish");
        done = 1;
        summary();
    end

    logic [15:0] lfsr = 16'hACE1;

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check("R1 mask", {31'd0, mask_o}, 32'd1);
        check("R1 count", {16'd0, cur_cnt_o}, 32'd0);
        check("R1 addr", {16'd0, cur_addr_o}, 32'd0);
        check("R1 strobe", {31'd0, xfer_stb}, 32'd0);

        // block of 3 units, no refill
        wr_addr_en = 1; wr_addr_val = 16'h1000; wr_cnt_en = 1; wr_cnt_val = 16'd2;
        page_sel = 8'h35; auto_init = 0;
        step(1);
        wr_addr_en = 0; wr_cnt_en = 0; dreq = 1;
        step(2);
        check("R2 masked no move", {31'd0, xfer_stb}, 32'd0);
        mask_clr = 1;
        step(1);
        mask_clr = 0;
        check("R9 unmask event", {31'd0, unmask_evt}, 32'd1);
        n_stb = 0; n_tc = 0;
        step(3);
        check("R8 count rolled", {16'd0, cur_cnt_o}, 32'h0000FFFF);
        check("R8 addr advanced", {16'd0, cur_addr_o}, 32'h00001003);
        check("R8 self masked", {31'd0, mask_o}, 32'd1);
        step(2);
        check("R6 unit count", n_stb, 32'd3);
        check("R6 tc count", n_tc, 32'd1);
        dreq = 0;

        // refill block of 2 units
        auto_init = 1;
        wr_addr_en = 1; wr_addr_val = 16'h2000; wr_cnt_en = 1; wr_cnt_val = 16'd1;
        mask_clr = 1;
        step(1);
        wr_addr_en = 0; wr_cnt_en = 0; mask_clr = 0; dreq = 1;
        step(2);
        dreq = 0;
        check("R7 addr refilled", {16'd0, cur_addr_o}, 32'h00002000);
        check("R7 count refilled", {16'd0, cur_cnt_o}, 32'd1);
        check("R7 stays open", {31'd0, mask_o}, 32'd0);
        check("R7 tc pulse", {31'd0, tc_pulse}, 32'd1);
        step(1);

        // host load collides with a unit move
        dreq = 1; wr_addr_en = 1; wr_addr_val = 16'h4444;
        step(1);
        dreq = 0; wr_addr_en = 0;
        check("R10 moved", {31'd0, xfer_stb}, 32'd1);
        check("R10 host wins", {16'd0, cur_addr_o}, 32'h00004444);
        check("R10 old phys", {8'd0, phys_addr}, 32'h00352000);

        // wrap inside the page
        wr_addr_en = 1; wr_addr_val = 16'hFFFF; wr_cnt_en = 1; wr_cnt_val = 16'd5;
        page_sel = 8'h07;
        step(1);
        wr_addr_en = 0; wr_cnt_en = 0; dreq = 1;
        step(1);
        check("R4 byte phys", {8'd0, phys_addr}, 32'h0007FFFF);
        check("R5 word phys", {8'd0, phys_w}, 32'h0007FFFE);
        check("R3 count step", {16'd0, cur_cnt_o}, 32'd4);
        step(1);
        dreq = 0;
        check("R11 wrap byte", {8'd0, phys_addr}, 32'h00070000);
        check("R11 wrap word", {8'd0, phys_w}, 32'h00060000);

        // set and clear together
        mask_set = 1; mask_clr = 1;
        step(1);
        check("R12 set wins", {31'd0, mask_o}, 32'd1);
        check("R9 mask event", {31'd0, mask_evt}, 32'd1);
        mask_clr = 0;
        step(1);
        mask_set = 0;
        check("R9 no repeat event", {31'd0, mask_evt}, 32'd0);

        // self-mask versus clear at block end
        auto_init = 0;
        wr_cnt_en = 1; wr_cnt_val = 16'd0; mask_clr = 1;
        step(1);
        wr_cnt_en = 0; dreq = 1;
        step(1);
        check("R12 self mask beats clear", {31'd0, mask_o}, 32'd1);
        mask_clr = 0; dreq = 0;
        step(1);

        // pseudo-random phase
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            dreq        = lfsr[0] | lfsr[1];
            mask_clr    = (lfsr[3:2] == 2'b00);
            mask_set    = (lfsr[6:4] == 3'b000);
            wr_addr_en  = (lfsr[9:7] == 3'b000);
            wr_addr_val = {lfsr[15:8], lfsr[7:0]};
            wr_cnt_en   = (lfsr[12:10] == 3'b000);
            wr_cnt_val  = {13'd0, lfsr[15:13]};
            if (lfsr[11:9] == 3'b111) auto_init = ~auto_init;
            if (lfsr[14:12] == 3'b101) page_sel = lfsr[7:0];
            step(1);
        end
        dreq = 0; mask_set = 0; mask_clr = 0; wr_addr_en = 0; wr_cnt_en = 0;
        step(2);
        done = 1;
        summary();
    end
endmodule